// File: doc/BRIEF.md
# Programmable Local Countdown Timer

The block is a down-counting timer for a processor core's interrupt logic. Software programs it through three writable registers: a control word, a divide code and a start value. The control word holds the interrupt vector, a mask flag and a mode field. The divide code selects a prescaler ratio. Writing the start value loads it into the live counter and starts the countdown. The counter decrements once per prescaled tick. When it expires, the timer emits a one-cycle interrupt request tagged with the programmed vector.

There are two running modes. In single-shot mode the counter stops at zero after a single request. In repeating mode it reloads from the start value on every expiry. The mode field can be rewritten while the timer runs. The live count is never touched by this, so counting carries on from where it was. A single-shot timer that has already expired stays at zero when it is switched to repeating. The third mode encoding is reserved for an externally timed deadline scheme that is not built here, and it freezes the counter.

Register select on `wrSel`: 0 = control word, 1 = divide code, 2 = start value, 3 = no register. Control word fields: vector in bits 7:0, mask in bit 16, mode in bits 18:17 (0 single-shot, 1 repeating, 2 deadline, 3 treated as deadline).

Top module: `local_countdown_timer`

## Requirements
- R1: After reset, curCount and initCount read 0, irqPulse and irqVector are 0, the mask bit is set, the mode is single-shot and the divide code is 0 (divide-by-2).
- R2: A write with wrSel=2 loads wrData into both initCount and curCount at that clock edge and restarts the prescaler. With divide code 0xB, curCount then falls by one on every following edge.
- R3: Divide codes (wrData[3:0] with wrSel=1) 0x0, 0x1, 0x2, 0x3, 0x8, 0x9, 0xA, 0xB give one decrement every 2, 4, 8, 16, 32, 64, 128 and 1 cycles. After a start value N is written, expiry falls N*ratio edges after the load edge.
- R4: In single-shot mode (bits 18:17 = 0), the edge that takes curCount from 1 expires the timer. curCount ends at 0 and stays there, and irqPulse is high for exactly one cycle with irqVector equal to bits 7:0 of the control word.
- R5: In repeating mode (bits 18:17 = 1), the expiring edge reloads curCount from initCount instead of 0 and raises irqPulse. This repeats every N*ratio cycles.
- R6: Writing the control word never changes initCount.
- R7: Changing the mode between single-shot and repeating while counting neither reloads nor stalls curCount. The next decrement continues from the present value.
- R8: A single-shot timer that has reached 0 and is switched to repeating keeps curCount at 0 and raises no request.
- R9: With the mask bit (bit 16) set, curCount keeps counting and expires as usual, but irqPulse stays low.
- R10: Writing a start value of 0 stops the timer: curCount reads 0 from the next cycle and no request follows.
- R11: With mode bits 18:17 = 2 or 3, curCount holds its value and no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 control, 1 divide, 2 start value |
| wrData | input | 32 | Write data |
| curCount | output | 32 | Live count value |
| initCount | output | 32 | Start value register read-back |
| irqPulse | output | 1 | One-cycle interrupt request on expiry |
| irqVector | output | 8 | Vector carried by the last request |

## Verification
The assertions assume that wrSel is only meaningful while wrEn is high. They also assume that a mask-bit change takes effect at the same edge as any expiry that edge produces. They further assume that a start-value write on an expiring edge replaces the expiry. The stimulus never combines a start-value write with an expiry edge, and it changes the control word only on cycles whose counter value is known. Every expected edge therefore follows directly from the count and ratio rules in the requirements.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int DIV_SEL_W = 3;
  localparam int SHIFT_W   = 3;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_DEADLN = 2'd2,
    MODE_RSVD   = 2'd3
  } tmrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               load;
    logic               countEn;
    logic               periodic;
    logic [SHIFT_W-1:0] divShift;
  } tmrStrobe_t;
endpackage

// File: rtl/lct_ctrl.sv
module lct_ctrl
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             expireStb,
  output tmrStrobe_t       strb,
  output logic [CNT_W-1:0] initReg,
  output logic             irqPulse,
  output logic [VEC_W-1:0] irqVec
);
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_DIV  = 2'd1;
  localparam logic [1:0] SEL_INIT = 2'd2;
  localparam int MASK_BIT = 16;
  localparam int MODE_LSB = MASK_BIT + 1;
  localparam logic [DIV_SEL_W-1:0] SEL_DIV1 = '1;

  logic [VEC_W-1:0]     vecReg;
  logic                 maskReg;
  tmrMode_e             modeReg;
  logic [DIV_SEL_W-1:0] divSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg   <= '0;
      maskReg  <= 1'b1;
      modeReg  <= MODE_SINGLE;
      divSel   <= '0;
      initReg  <= '0;
      irqPulse <= 1'b0;
      irqVec   <= '0;
    end else begin
      if (wrEn && wrSel == SEL_CFG) begin
        vecReg  <= wrData[VEC_W-1:0];
        maskReg <= wrData[MASK_BIT];
        modeReg <= tmrMode_e'(wrData[MODE_LSB+1:MODE_LSB]);
      end
      if (wrEn && wrSel == SEL_DIV)
        divSel <= {wrData[3], wrData[1:0]};
      if (wrEn && wrSel == SEL_INIT)
        initReg <= wrData;
      irqPulse <= expireStb && !maskReg;
      if (expireStb && !maskReg)
        irqVec <= vecReg;
    end
  end

  always_comb begin
    strb.load     = wrEn && (wrSel == SEL_INIT);
    strb.countEn  = (modeReg == MODE_SINGLE) || (modeReg == MODE_REPEAT);
    strb.periodic = (modeReg == MODE_REPEAT);
    strb.divShift = (divSel == SEL_DIV1) ? SHIFT_W'(0) : SHIFT_W'(divSel + 1'b1);
  end

  // R9
  mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !$past(maskReg));

  // R6
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrSel == SEL_INIT) |=> $stable(initReg));
endmodule

// File: rtl/lct_datapath.sv
module lct_datapath
  import lct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] curCount,
  output logic             expireStb
);
  localparam int PRE_W = (2 ** DIV_SEL_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preMask;
  logic             tick;
  logic             atOne;

  always_comb begin
    for (int i = 0; i < PRE_W; i++)
      preMask[i] = (i < int'(strb.divShift));
  end

  assign tick      = ((pre & preMask) == preMask);
  assign atOne     = (curCount == CNT_W'(1));
  assign expireStb = !strb.load && tick && strb.countEn && atOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre      <= '0;
      curCount <= '0;
    end else if (strb.load) begin
      pre      <= '0;
      curCount <= loadVal;
    end else begin
      pre <= tick ? '0 : PRE_W'(pre + 1'b1);
      if (tick && strb.countEn && curCount != '0) begin
        if (atOne)
          curCount <= strb.periodic ? initVal : '0;
        else
          curCount <= curCount - 1'b1;
      end
    end
  end

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.countEn) |=> $stable(curCount));

  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !(strb.periodic && atOne)) |=> curCount <= $past(curCount));

  // R8
  zero_stick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && curCount == '0) |=> curCount == '0);
endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] curCount,
  output logic [CNT_W-1:0] initCount,
  output logic             irqPulse,
  output logic [VEC_W-1:0] irqVector
);
  tmrStrobe_t strb;
  logic       expireStb;

  lct_ctrl #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .expireStb(expireStb), .strb(strb), .initReg(initCount),
    .irqPulse(irqPulse), .irqVec(irqVector)
  );

  lct_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wrData),
    .initVal(initCount), .curCount(curCount), .expireStb(expireStb)
  );

  // R4
  expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(curCount) == CNT_W'(1));
endmodule

// File: tb/local_countdown_timer_tb.sv
`timescale 1ns/1ps
module local_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [31:0] wrData = '0;
  logic [31:0] curCount, initCount;
  logic        irqPulse;
  logic [7:0]  irqVector;

  int compared = 0;
  int mismatched = 0;
  int k = 0;
  int irqCnt = 0;
  int firstIrq = -1;
  bit done = 1'b0;

  // {divide code, start value}
  localparam logic [35:0] TABLE [8] = '{
    {4'hB, 32'd7}, {4'h0, 32'd5}, {4'h1, 32'd3}, {4'h2, 32'd4},
    {4'h3, 32'd2}, {4'h8, 32'd3}, {4'h9, 32'd2}, {4'hA, 32'd2}
  };

  always #10 clk = ~clk;

  local_countdown_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .curCount(curCount), .initCount(initCount),
    .irqPulse(irqPulse), .irqVector(irqVector)
  );

  function automatic int ratioOf(input logic [3:0] code);
    case (code)
      4'h0: return 2;   4'h1: return 4;   4'h2: return 8;   4'h3: return 16;
      4'h8: return 32;  4'h9: return 64;  4'hA: return 128; default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] cfgWord(input int mode, input bit mask, input logic [7:0] vec);
    return (32'(mode) << 17) | (32'(mask) << 16) | 32'(vec);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stepSample();
    k++;
    if (irqPulse) begin
      irqCnt++;
      if (firstIrq < 0) firstIrq = k;
    end
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stepSample();
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd3;
    stepSample();
  endtask

  task automatic startCount(input logic [31:0] n);
    writeReg(2'd2, n);
    k = 0; irqCnt = 0; firstIrq = -1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(curCount == 0, "R1 curCount", curCount, 0);
    check(initCount == 0, "R1 initCount", initCount, 0);
    check(irqPulse == 0 && irqVector == 0, "R1 irq", irqPulse, 0);
    // R1 mask set after reset: start with no config write
    writeReg(2'd1, 32'hB);
    startCount(32'd2);
    runCycles(4);
    check(irqCnt == 0 && curCount == 0, "R1 mask default", irqCnt, 0);

    // table walk: R2 R3 R4
    for (int t = 0; t < 8; t++) begin
      logic [3:0]  code;
      logic [31:0] n;
      int          expK;
      code = TABLE[t][35:32];
      n    = TABLE[t][31:0];
      expK = int'(n) * ratioOf(code);
      writeReg(2'd0, cfgWord(0, 1'b0, 8'h20 + 8'(t)));
      writeReg(2'd1, 32'(code));
      startCount(n);
      check(curCount == n && initCount == n, "R2 load", curCount, n);
      runCycles(expK + 3);
      check(firstIrq == expK, "R3 expiry edge", firstIrq, expK);
      check(irqCnt == 1, "R4 single request", irqCnt, 1);
      check(curCount == 0, "R4 stop at zero", curCount, 0);
      check(irqVector == 8'h20 + 8'(t), "R4 vector", irqVector, 8'h20 + t);
    end

    // R2 per-cycle decrement at divide-by-1
    writeReg(2'd1, 32'hB);
    startCount(32'd9);
    runCycles(3);
    check(curCount == 6, "R2 decrement", curCount, 6);

    // R5 repeating mode
    writeReg(2'd0, cfgWord(1, 1'b0, 8'h5A));
    startCount(32'd4);
    runCycles(4);
    check(curCount == 4, "R5 reload", curCount, 4);
    check(irqPulse == 1 && irqVector == 8'h5A, "R5 vector", irqVector, 8'h5A);
    runCycles(9);
    check(irqCnt == 3, "R5 repeat count", irqCnt, 3);

    // R7 switch repeating -> single-shot mid count, then R8
    startCount(32'd10);
    runCycles(3);
    writeReg(2'd0, cfgWord(0, 1'b0, 8'h11));
    check(curCount == 6, "R7 no reload on switch", curCount, 6);
    check(initCount == 10, "R6 init kept", initCount, 10);
    runCycles(6);
    check(firstIrq == 10 && curCount == 0, "R7 expiry continues", firstIrq, 10);
    runCycles(2);
    writeReg(2'd0, cfgWord(1, 1'b0, 8'h11));
    runCycles(20);
    check(curCount == 0, "R8 stays zero", curCount, 0);
    check(irqCnt == 1, "R8 no request", irqCnt, 1);
    check(initCount == 10, "R6 init kept after switch", initCount, 10);

    // R7 single-shot -> repeating mid count
    writeReg(2'd0, cfgWord(0, 1'b0, 8'h12));
    startCount(32'd10);
    runCycles(3);
    writeReg(2'd0, cfgWord(1, 1'b0, 8'h12));
    check(curCount == 6, "R7 no reload to repeating", curCount, 6);
    runCycles(6);
    check(firstIrq == 10 && curCount == 10, "R7 repeat reload", curCount, 10);

    // R9 mask
    writeReg(2'd0, cfgWord(0, 1'b1, 8'h33));
    startCount(32'd5);
    runCycles(2);
    check(curCount == 3, "R9 counts while masked", curCount, 3);
    runCycles(8);
    check(irqCnt == 0 && curCount == 0, "R9 suppressed", irqCnt, 0);

    // R10 zero start stops
    writeReg(2'd0, cfgWord(0, 1'b0, 8'h44));
    startCount(32'd20);
    runCycles(3);
    startCount(32'd0);
    check(curCount == 0, "R10 stopped", curCount, 0);
    runCycles(30);
    check(irqCnt == 0 && curCount == 0, "R10 no request", irqCnt, 0);

    // R11 deadline and reserved encodings freeze
    writeReg(2'd0, cfgWord(2, 1'b0, 8'h55));
    startCount(32'd8);
    runCycles(5);
    check(curCount == 8 && irqCnt == 0, "R11 deadline freeze", curCount, 8);
    writeReg(2'd0, cfgWord(3, 1'b0, 8'h55));
    runCycles(5);
    check(curCount == 8 && irqCnt == 0, "R11 reserved freeze", curCount, 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule